// File: doc/BRIEF.md
# Pixel Transfer Engine with Tiled Layouts and Box Downscale

The engine copies an image of 32-bit RGBA pixels from a source buffer to a destination buffer. Each side is stored either as plain row-major pixels or as 8x8 tiles, and inside a tile the pixels follow a Z-order (bit-interleaved) sequence. Two layout flags pick the combination. The engine can also shrink the image by two in X, or by two in X and Y, by averaging pixels that are neighbours in tiled memory order. It can write the rows in reverse order.

A transfer begins with a single-cycle start pulse. The engine captures the configuration on that pulse and checks it. If the configuration is valid, the engine walks the destination pixels row by row. For each pixel it reads one, two or four source words, sums them per channel, and writes one destination word. It raises a completion pulse with the final write. An invalid configuration produces an error pulse, and the engine then returns to idle without touching memory.

The memory read port has a fixed latency of one cycle: data for a read issued in cycle t arrives in cycle t+1. The write port takes one word per cycle and has no back-pressure.

Top module: `pix_xfer_engine`

## Requirements
- R1: After reset the engine is idle, and busy, done, error, read enable and write enable are all low.
- R2: A pixel at (x, y) in a linear image of width W pixels sits at byte offset (x + y*W)*4 from its base address.
- R3: A pixel at (x, y) in a tiled image of width W sits at byte offset 4*(T + (x with low 3 bits cleared)*8 + (y with low 3 bits cleared)*W). T is the 6-bit tile index whose bits from LSB upward are x[0], y[0], x[1], y[1], x[2], y[2].
- R4: The layout flags select the layouts as follows. Linear-in=1, keep=0: linear source, tiled destination. Linear-in=1, keep=1: both linear. Linear-in=0, keep=0: tiled source, linear destination. Linear-in=0, keep=1: both tiled. The source stride is the input width. The destination stride is the effective output width.
- R5: The scale codes are 0 (none), 1 (X), 2 (XY). Under codes 1 and 2 the effective output width is the configured output width shifted right by one. Under code 2 the effective output height is also halved. The source coordinates are the destination coordinates shifted left by one on each halved axis.
- R6: Under code 1 each output channel is the truncated mean of the words at the source offset and the next 4 bytes. Under code 2 it is the truncated mean of four consecutive words. Channels are the four bytes of the word.
- R7: With flip set, destination row y of the walk is written to row (effective height - 1 - y). The source row is still taken from the unflipped y.
- R8: The engine rejects a transfer in any of these cases: scale code 3; a nonzero scale with linear input; a zero input width, input height, output width or output height; or a zero effective output dimension. On rejection it pulses the error output for one cycle, issues no read or write, and returns to idle.
- R9: A valid transfer makes exactly (effective width * effective height) writes in row-major order of the walk. Its done output pulses once, in the cycle of the last write, and is never high together with error.
- R10: A start pulse while the engine is busy is ignored, and the captured configuration holds until the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cfg_lin_in_i | input | 1 | Source is linear (1) or tiled (0) |
| cfg_keep_i | input | 1 | Keep layout (1) or convert layout (0) |
| cfg_flip_i | input | 1 | Write rows in reverse order |
| cfg_scale_i | input | 2 | Scale code: 0 none, 1 X, 2 XY, 3 invalid |
| cfg_in_w_i | input | DIM_W | Source width in pixels |
| cfg_in_h_i | input | DIM_W | Source height in pixels |
| cfg_out_w_i | input | DIM_W | Configured output width before scaling |
| cfg_out_h_i | input | DIM_W | Configured output height before scaling |
| cfg_src_i | input | ADDR_W | Source byte base address |
| cfg_dst_i | input | ADDR_W | Destination byte base address |
| busy_o | output | 1 | A transfer is being checked or run |
| done_o | output | 1 | Pulses with the last write |
| err_o | output | 1 | Pulses on a rejected configuration |
| rd_en_o | output | 1 | Source read request |
| rd_addr_o | output | ADDR_W | Source read byte address |
| rd_data_i | input | 32 | Read data, valid one cycle after the request |
| wr_en_o | output | 1 | Destination write strobe |
| wr_addr_o | output | ADDR_W | Destination write byte address |
| wr_data_o | output | 32 | Destination pixel |

## Verification
The assertions rely on the memory returning read data exactly one cycle after each request. They also rely on start being a pulse whose configuration inputs are stable in the same cycle. The bench memory model meets the latency by construction, and the bench drives every configuration at the falling edge together with start.

The per-channel sum bound and the coordinate-range checks hold only if a pixel never takes more reads than its scale code allows. The bench keeps dimensions at 16 or below so that every source and destination offset falls inside the modelled buffers. In the random cases it uses scaling only with tiled input and gives scaled cases an output width of at least two.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam int PIX_W  = 32;
  localparam int CH_W   = 8;
  localparam int NCH    = PIX_W / CH_W;
  localparam int BPP    = PIX_W / 8;
  localparam int BPP_SH = $clog2(BPP);
  localparam int SUM_W  = CH_W + 2;

  typedef enum logic [1:0] {
    SCL_NONE = 2'd0,
    SCL_X    = 2'd1,
    SCL_XY   = 2'd2,
    SCL_BAD  = 2'd3
  } scale_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_READ  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_WRITE = 3'd4
  } seq_st_e;

  // Z-order index of a pixel inside its 8x8 tile
  function automatic logic [5:0] tile_index(input logic [2:0] tx, input logic [2:0] ty);
    return {ty[2], tx[2], ty[1], tx[1], ty[0], tx[0]};
  endfunction

endpackage

// File: rtl/xfer_offset.sv
module xfer_offset
  import xfer_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic [DIM_W-1:0]  px_i,
  input  logic [DIM_W-1:0]  py_i,
  input  logic [DIM_W-1:0]  stride_i,
  input  logic              tiled_i,
  output logic [ADDR_W-1:0] off_o
);

  logic [ADDR_W-1:0] lin_pix;
  logic [ADDR_W-1:0] tile_pix;
  logic [ADDR_W-1:0] sel_pix;

  always_comb begin
    lin_pix  = ADDR_W'(px_i) + ADDR_W'(py_i) * ADDR_W'(stride_i);
    tile_pix = ADDR_W'(tile_index(px_i[2:0], py_i[2:0]))
             + ADDR_W'({px_i[DIM_W-1:3], 6'b0})
             + ADDR_W'({py_i[DIM_W-1:3], 3'b0}) * ADDR_W'(stride_i);
    sel_pix  = tiled_i ? tile_pix : lin_pix;
    off_o    = sel_pix << BPP_SH;
  end

endmodule

// File: rtl/xfer_avg.sv
module xfer_avg
  import xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [PIX_W-1:0] din_i,
  input  logic [1:0]       shift_i,
  output logic [PIX_W-1:0] dout_o
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_d;
    logic             sum_ce;

    always_comb begin
      sum_ce = clr_i | en_i;
      if (clr_i) sum_d = '0;
      else       sum_d = sum_q + SUM_W'(din_i[ch*CH_W +: CH_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q <= '0;
      else if (sum_ce) sum_q <= sum_d;
    end

    assign dout_o[ch*CH_W +: CH_W] = CH_W'(sum_q >> shift_i);

    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sum_q <= SUM_W'(4 * ((1 << CH_W) - 1))); // R6
  end

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cfg_ok_i,
  input  logic [DIM_W-1:0] ow_i,
  input  logic [DIM_W-1:0] oh_i,
  input  logic [2:0]       nrd_i,
  output logic             cfg_load_o,
  output logic [DIM_W-1:0] x_o,
  output logic [DIM_W-1:0] y_o,
  output logic [1:0]       k_o,
  output logic             rd_en_o,
  output logic             acc_clr_o,
  output logic             acc_en_o,
  output logic             wr_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  seq_st_e          st_q, st_d;
  logic [DIM_W-1:0] x_q, x_d, y_q, y_d;
  logic [1:0]       k_q, k_d;
  logic             pend_q;
  logic [2:0]       rdc_q, rdc_d;

  always_comb begin
    st_d       = st_q;
    x_d        = x_q;
    y_d        = y_q;
    k_d        = k_q;
    cfg_load_o = 1'b0;
    rd_en_o    = 1'b0;
    acc_clr_o  = 1'b0;
    wr_en_o    = 1'b0;
    done_o     = 1'b0;
    err_o      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          cfg_load_o = 1'b1;
          st_d       = ST_CHECK;
        end
      end
      ST_CHECK: begin
        acc_clr_o = 1'b1;
        x_d       = '0;
        y_d       = '0;
        k_d       = '0;
        if (cfg_ok_i) st_d = ST_READ;
        else begin
          err_o = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_READ: begin
        rd_en_o = 1'b1;
        k_d     = k_q + 2'd1;
        if (({1'b0, k_q} + 3'd1) == nrd_i) begin
          k_d  = '0;
          st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: st_d = ST_WRITE;
      ST_WRITE: begin
        wr_en_o   = 1'b1;
        acc_clr_o = 1'b1;
        st_d      = ST_READ;
        if (x_q == ow_i - DIM_W'(1)) begin
          x_d = '0;
          if (y_q == oh_i - DIM_W'(1)) begin
            done_o = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            y_d = y_q + DIM_W'(1);
          end
        end else begin
          x_d = x_q + DIM_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (acc_clr_o)    rdc_d = '0;
    else if (rd_en_o) rdc_d = rdc_q + 3'd1;
    else              rdc_d = rdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      k_q    <= '0;
      pend_q <= 1'b0;
      rdc_q  <= '0;
    end else begin
      st_q   <= st_d;
      x_q    <= x_d;
      y_q    <= y_d;
      k_q    <= k_d;
      pend_q <= rd_en_o;
      rdc_q  <= rdc_d;
    end
  end

  assign x_o      = x_q;
  assign y_o      = y_q;
  assign k_o      = k_q;
  assign acc_en_o = pend_q;
  assign busy_o   = (st_q != ST_IDLE);

  AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {ST_READ, ST_DRAIN, ST_WRITE}) |-> (x_q < ow_i && y_q < oh_i)); // R9
  AST_READS_PER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (rdc_q == nrd_i)); // R6

endmodule

// File: rtl/pix_xfer_engine.sv
module pix_xfer_engine
  import xfer_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cfg_lin_in_i,
  input  logic              cfg_keep_i,
  input  logic              cfg_flip_i,
  input  logic [1:0]        cfg_scale_i,
  input  logic [DIM_W-1:0]  cfg_in_w_i,
  input  logic [DIM_W-1:0]  cfg_in_h_i,
  input  logic [DIM_W-1:0]  cfg_out_w_i,
  input  logic [DIM_W-1:0]  cfg_out_h_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [PIX_W-1:0]  rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [PIX_W-1:0]  wr_data_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  // captured configuration
  logic              cfg_load;
  logic              lin_q, keep_q, flip_q;
  scale_e            scale_q;
  logic [DIM_W-1:0]  in_w_q, in_h_q, out_w_q, out_h_q;
  logic [ADDR_W-1:0] src_q, dst_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lin_q   <= 1'b0;
      keep_q  <= 1'b0;
      flip_q  <= 1'b0;
      scale_q <= SCL_NONE;
      in_w_q  <= '0;
      in_h_q  <= '0;
      out_w_q <= '0;
      out_h_q <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else if (cfg_load) begin
      lin_q   <= cfg_lin_in_i;
      keep_q  <= cfg_keep_i;
      flip_q  <= cfg_flip_i;
      scale_q <= scale_e'(cfg_scale_i);
      in_w_q  <= cfg_in_w_i;
      in_h_q  <= cfg_in_h_i;
      out_w_q <= cfg_out_w_i;
      out_h_q <= cfg_out_h_i;
      src_q   <= cfg_src_i;
      dst_q   <= cfg_dst_i;
    end
  end

  // derived walk parameters
  logic             hs, vs, cfg_ok;
  logic [DIM_W-1:0] ow_eff, oh_eff;
  logic [2:0]       nrd;
  logic [1:0]       avg_sh;

  always_comb begin
    hs     = (scale_q != SCL_NONE);
    vs     = (scale_q == SCL_XY);
    ow_eff = hs ? (out_w_q >> 1) : out_w_q;
    oh_eff = vs ? (out_h_q >> 1) : out_h_q;
    nrd    = vs ? 3'd4 : (hs ? 3'd2 : 3'd1);
    avg_sh = {vs, hs & ~vs};
    cfg_ok = (in_w_q != '0) && (in_h_q != '0) && (out_w_q != '0) && (out_h_q != '0)
          && (ow_eff != '0) && (oh_eff != '0) && (scale_q != SCL_BAD)
          && !(lin_q && hs);
  end

  // sequencer
  logic [DIM_W-1:0] x, y;
  logic [1:0]       k;
  logic             acc_clr, acc_en;

  xfer_seq #(.DIM_W(DIM_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (start_i),
    .cfg_ok_i  (cfg_ok),
    .ow_i      (ow_eff),
    .oh_i      (oh_eff),
    .nrd_i     (nrd),
    .cfg_load_o(cfg_load),
    .x_o       (x),
    .y_o       (y),
    .k_o       (k),
    .rd_en_o   (rd_en_o),
    .acc_clr_o (acc_clr),
    .acc_en_o  (acc_en),
    .wr_en_o   (wr_en_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  // coordinates
  logic [DIM_W-1:0] ix, iy, oy;
  always_comb begin
    ix = hs ? {x[DIM_W-2:0], 1'b0} : x;
    iy = vs ? {y[DIM_W-2:0], 1'b0} : y;
    oy = flip_q ? (oh_eff - DIM_W'(1) - y) : y;
  end

  // offsets
  logic [ADDR_W-1:0] src_off, dst_off;

  xfer_offset #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_src_off (
    .px_i    (ix),
    .py_i    (iy),
    .stride_i(in_w_q),
    .tiled_i (~lin_q),
    .off_o   (src_off)
  );

  xfer_offset #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_dst_off (
    .px_i    (x),
    .py_i    (oy),
    .stride_i(ow_eff),
    .tiled_i (lin_q ^ keep_q),
    .off_o   (dst_off)
  );

  assign rd_addr_o = src_q + src_off + ADDR_W'({k, 2'b00});
  assign wr_addr_o = dst_q + dst_off;

  // channel averaging
  xfer_avg u_avg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr_i  (acc_clr),
    .en_i   (acc_en),
    .din_i  (rd_data_i),
    .shift_i(avg_sh),
    .dout_o (wr_data_o)
  );

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(rd_en_o && wr_en_o)); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(done_o && err_o)); // R9
  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |=> (!busy_o && !rd_en_o && !wr_en_o)); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && $past(busy_o)) |-> ($stable(scale_q) && $stable(src_q) && $stable(dst_q)
                                   && $stable(out_w_q) && $stable(lin_q))); // R10

endmodule

// File: tb/pix_xfer_engine_test.sv
`timescale 1ns/1ps
module pix_xfer_engine_test;

  localparam int DIM_W  = 12;
  localparam int ADDR_W = 32;
  localparam int NWORDS = 2048;
  localparam logic [31:0] DST_BASE = 32'h2000;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              start, lin, keep, flip;
  logic [1:0]        scale;
  logic [DIM_W-1:0]  in_w, in_h, out_w, out_h;
  logic              busy, done, err, rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [31:0]       rd_data, wr_data;

  pix_xfer_engine #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cfg_lin_in_i(lin), .cfg_keep_i(keep), .cfg_flip_i(flip), .cfg_scale_i(scale),
    .cfg_in_w_i(in_w), .cfg_in_h_i(in_h), .cfg_out_w_i(out_w), .cfg_out_h_i(out_h),
    .cfg_src_i(32'h0), .cfg_dst_i(DST_BASE),
    .busy_o(busy), .done_o(done), .err_o(err),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  logic [31:0] src_mem [0:NWORDS-1];
  logic [31:0] dst_mem [0:NWORDS-1];
  logic [31:0] expw    [0:NWORDS-1];
  logic        clr_dst;
  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, err_cnt = 0, cyc = 0;

  // memory model: one-cycle read latency, one write per cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      rd_data <= src_mem[rd_addr[12:2]];
      rd_cnt  <= rd_cnt + 1;
    end
    if (clr_dst) begin
      for (int i = 0; i < NWORDS; i++) dst_mem[i] <= SENT;
    end else if (wr_en) begin
      dst_mem[wr_addr[12:2]] <= wr_data;
    end
    if (wr_en) wr_cnt <= wr_cnt + 1;
    if (done)  done_cnt <= done_cnt + 1;
    if (err)   err_cnt <= err_cnt + 1;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(negedge clk) begin
    if (cyc >= 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int tidx(int x, int y);
    return (x & 1) | ((y & 1) << 1) | (((x >> 1) & 1) << 2) | (((y >> 1) & 1) << 3)
         | (((x >> 2) & 1) << 4) | (((y >> 2) & 1) << 5);
  endfunction

  // byte offset per R2 / R3
  function automatic int pix_off(int x, int y, int w, bit tiled);
    if (tiled) return 4 * (tidx(x, y) + (x & ~7) * 8 + (y & ~7) * w);
    return 4 * (x + y * w);
  endfunction

  task automatic run(input bit l, input bit kp, input bit fl, input int sc,
                     input int iw, input int ih, input int ow, input int oh,
                     input string tag, input bit poke);
    int hs, vs, eow, eoh, nrd, w0, r0, d0, e0;
    bit valid;
    for (int i = 0; i < NWORDS; i++) begin
      src_mem[i] = $urandom;
      expw[i]    = SENT;
    end
    @(negedge clk); clr_dst = 1'b1;
    @(negedge clk); clr_dst = 1'b0;
    hs  = (sc != 0) ? 1 : 0;
    vs  = (sc == 2) ? 1 : 0;
    eow = ow >> hs;
    eoh = oh >> vs;
    nrd = 1 << (hs + vs);
    valid = iw != 0 && ih != 0 && ow != 0 && oh != 0 && sc != 3 && !(l && sc != 0)
            && eow != 0 && eoh != 0;
    if (valid) begin
      for (int y = 0; y < eoh; y++) begin
        for (int x = 0; x < eow; x++) begin
          int so, dof, oy;
          logic [31:0] px;
          oy  = fl ? (eoh - 1 - y) : y;
          so  = pix_off(x << hs, y << vs, iw, !l);
          dof = pix_off(x, oy, eow, l ^ kp);
          for (int ch = 0; ch < 4; ch++) begin
            int s = 0;
            for (int j = 0; j < nrd; j++) s += int'(src_mem[(so >> 2) + j][ch*8 +: 8]);
            px[ch*8 +: 8] = 8'(s >> (hs + vs));
          end
          expw[dof >> 2] = px;
        end
      end
    end
    w0 = wr_cnt; r0 = rd_cnt; d0 = done_cnt; e0 = err_cnt;
    lin = l; keep = kp; flip = fl; scale = 2'(sc);
    in_w = DIM_W'(iw); in_h = DIM_W'(ih); out_w = DIM_W'(ow); out_h = DIM_W'(oh);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      check(busy === 1'b1, "R10", "busy before second start", busy, 1);
      scale = 2'd3; in_w = '0; lin = ~l; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt == d0 && err_cnt == e0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (valid) begin
      check(done_cnt == d0 + 1, tag, "done pulses (R9)", done_cnt - d0, 1);
      check(err_cnt == e0, tag, "error pulses (R8)", err_cnt - e0, 0);
      check(wr_cnt - w0 == eow * eoh, tag, "write count (R9)", wr_cnt - w0, eow * eoh);
      check(rd_cnt - r0 == eow * eoh * nrd, tag, "read count (R6)", rd_cnt - r0,
            eow * eoh * nrd);
    end else begin
      check(err_cnt == e0 + 1, tag, "error pulse (R8)", err_cnt - e0, 1);
      check(done_cnt == d0, tag, "no done (R8)", done_cnt - d0, 0);
      check(wr_cnt == w0 && rd_cnt == r0, tag, "no memory access (R8)",
            (wr_cnt - w0) + (rd_cnt - r0), 0);
    end
    begin
      int stray = 0;
      for (int i = 0; i < NWORDS; i++) begin
        if (expw[i] != SENT)
          check(dst_mem[i] == expw[i], tag, $sformatf("pixel word %0d", i), dst_mem[i], expw[i]);
        else if (dst_mem[i] != SENT) stray++;
      end
      check(stray == 0, tag, "words outside the image untouched", stray, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; clr_dst = 1'b0;
    lin = 1'b0; keep = 1'b0; flip = 1'b0; scale = 2'd0;
    in_w = '0; in_h = '0; out_w = '0; out_h = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !err && !rd_en && !wr_en, "R1", "idle outputs after reset",
          {busy, done, err, rd_en, wr_en}, 0);

    run(1, 1, 0, 0,  8,  8,  8,  8, "R2", 0);
    run(1, 0, 0, 0, 16,  8, 16,  8, "R3", 0);
    run(0, 0, 0, 0, 16, 16, 16, 16, "R3", 0);
    run(0, 1, 0, 0,  8, 16,  8, 16, "R4", 0);
    run(1, 1, 0, 0,  5,  7,  5,  7, "R4", 0);
    run(0, 0, 0, 1, 16,  8, 16,  8, "R5", 0);
    run(0, 1, 0, 1,  6,  4,  6,  4, "R5", 0);
    run(0, 1, 0, 2, 16, 16, 16, 16, "R6", 0);
    run(0, 0, 0, 2,  8,  8,  8,  8, "R6", 0);
    run(1, 1, 1, 0,  5,  7,  5,  7, "R7", 0);
    run(0, 0, 1, 2, 16, 16, 16, 16, "R7", 0);
    run(1, 0, 1, 0, 16, 12, 16, 12, "R7", 0);
    // rejections
    run(0, 0, 0, 3,  8,  8,  8,  8, "R8", 0);
    run(1, 0, 0, 1,  8,  8,  8,  8, "R8", 0);
    run(0, 0, 0, 0,  0,  8,  8,  8, "R8", 0);
    run(0, 0, 0, 0,  8,  0,  8,  8, "R8", 0);
    run(0, 0, 0, 0,  8,  8,  8,  0, "R8", 0);
    run(0, 0, 0, 1,  8,  8,  1,  8, "R8", 0);
    // start while busy
    run(0, 0, 0, 1, 16, 16, 16, 16, "R10", 1);
    // random cases
    for (int t = 0; t < 20; t++) begin
      bit rl, rk, rf;
      int rs, w, h;
      rl = 1'($urandom % 2);
      rk = 1'($urandom % 2);
      rf = 1'($urandom % 2);
      rs = rl ? 0 : int'($urandom % 3);
      w  = (rs != 0) ? 2 + int'($urandom % 15) : 1 + int'($urandom % 16);
      h  = (rs == 2) ? 2 + int'($urandom % 15) : 1 + int'($urandom % 16);
      run(rl, rk, rf, rs, w, h, w, h, "R4", 0);
    end
    summary();
    $finish;
  end

endmodule